// File: doc/BRIEF.md
# Two-Bank SDRAM Command Sequencer

This block sits on the controller side of a two-bank synchronous DRAM with 2048 rows per bank. It takes one request at a time from a user port and turns it into the row-strobe, column-strobe, write-enable and address pin pattern of the memory. There are four request kinds: open a row, read a column, close one bank, and close both banks. The block tracks whether each bank is idle or open, and which row is open. Per-bank cycle counters enforce the open-to-read delay, the shortest allowed open time and the longest allowed open time.

A request that is legal but comes too early is held off. `req_ready` stays low until the timing window is met, so the request is never lost. A request that can never be legal in the current bank state is consumed in one cycle and flagged on `req_err`. Examples are opening a bank that is already open, reading an idle bank or another row, and closing an idle bank. When a bank reaches its longest allowed open time, the block closes that bank by itself and stalls any user request in that cycle.

A single command register drives the pins. Its states are NOP, ACT (open row), RD (read), PRE (user close of one bank), PALL (close both banks) and FPRE (forced close of one bank). Each cycle the next state is picked as follows:
- A forced close (to FPRE) comes first.
- Otherwise a legal, timely request goes to ACT, RD, PRE or PALL.
- Otherwise the register returns to NOP. This covers an idle port, a stall and an error.

Each bank tracker has two states, IDLE and OPEN. IDLE goes to OPEN on an accepted open request. OPEN goes back to IDLE on any close that covers the bank.

Top module: `sdram_cmd_sequencer`

## Requirements
- R1: After reset the pins show NOP (`cmd_ras_n`, `cmd_cas_n` and `cmd_we_n` all 1), `cmd_addr` is 0 and `req_err` is 0.
- R2: An accepted open request (`req_op` = 2'b00) drives RAS#=0, CAS#=1, WE#=1 in the cycle after the accepting clock edge. The bank is on address bit 11 and the row on bits 10..0.
- R3: An accepted read (`req_op` = 2'b01) drives RAS#=1, CAS#=0, WE#=1 in the cycle after acceptance. The bank is on bit 11, the column on bits 7..0, and bits 10..8 are 0.
- R4: A close of one bank (`req_op` = 2'b10) drives RAS#=0, CAS#=1, WE#=0 with bit 10 = 0 and the bank on bit 11. A close of both banks (`req_op` = 2'b11) drives the same strobes with bit 10 = 1 and bit 11 = 0.
- R5: A read is accepted no earlier than T_RCD clock edges after the edge that accepted the open request of its bank. Until then `req_ready` is 0.
- R6: A single-bank close is accepted no earlier than T_RAS_MIN edges after that bank's open. A close of both banks waits until every open bank meets this limit.
- R7: An open bank is closed automatically (FPRE) on the edge exactly T_RAS_MAX edges after its open. A user request in that cycle is stalled by one cycle.
- R8: After any close a bank is idle and can be opened again without error. A close of both banks is legal when both banks are already idle.
- R9: The following requests are consumed on the next edge: opening an open bank, reading an idle bank, reading a row other than the open one, and closing an idle bank. Each one raises `req_err` for exactly one cycle and leaves NOP on the pins.
- R10: In every cycle with no command to issue, the pins show NOP with `cmd_addr` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 00 open row, 01 read, 10 close bank, 11 close both |
| req_bank | input | 1 | Target bank |
| req_row | input | 11 | Row for open and read requests |
| req_col | input | 8 | Column for read requests |
| req_ready | output | 1 | Request accepted or consumed on the next edge |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_addr | output | 12 | Memory address bus |
| req_err | output | 1 | One-cycle pulse after an illegal request |

## Verification
Every pin result and the error pulse are registered. Each one is due in the cycle that follows the rising edge on which `req_ready` was high with `req_valid`. The bench therefore samples them at the falling edge right after that edge. For stalled requests it counts rising edges and predicts the accepting edge as the later of the edge the request was first presented on and the open edge plus T_RCD or T_RAS_MIN. For the automatic close it expects the precharge pattern at the falling edge after open edge plus T_RAS_MAX, and it expects a request colliding with that edge to be accepted one edge later.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
    localparam int BANKS = 2;
    localparam int BK_W  = 1;

    typedef enum logic [1:0] {
        OP_ACT  = 2'b00,
        OP_RD   = 2'b01,
        OP_PRE  = 2'b10,
        OP_PALL = 2'b11
    } req_op_e;

    typedef enum logic [2:0] {
        CS_NOP,
        CS_ACT,
        CS_RD,
        CS_PRE,
        CS_PALL,
        CS_FPRE
    } cmd_state_e;

    typedef enum logic {
        BK_IDLE,
        BK_OPEN
    } bank_state_e;
endpackage

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
    import sdram_seq_pkg::*;
#(
    parameter int ROW_W     = 11,
    parameter int T_RCD     = 3,
    parameter int T_RAS_MIN = 6,
    parameter int T_RAS_MAX = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_go,
    input  logic             rd_go,
    input  logic             pre_go,
    input  logic [ROW_W-1:0] act_row,
    output logic             is_open,
    output logic [ROW_W-1:0] open_row,
    output logic             rd_ok,
    output logic             pre_ok,
    output logic             must_close
);
    localparam int CNT_W = $clog2(T_RAS_MAX + 1);
    localparam logic [CNT_W-1:0] RCD_L = CNT_W'(T_RCD);
    localparam logic [CNT_W-1:0] MIN_L = CNT_W'(T_RAS_MIN);
    localparam logic [CNT_W-1:0] MAX_L = CNT_W'(T_RAS_MAX);

    bank_state_e      state_q;
    logic [CNT_W-1:0] age_q;
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BK_IDLE;
            age_q   <= '0;
            row_q   <= '0;
        end else begin
            unique case (state_q)
                BK_IDLE: begin
                    if (act_go) begin
                        state_q <= BK_OPEN;
                        age_q   <= CNT_W'(1);
                        row_q   <= act_row;
                    end
                end
                BK_OPEN: begin
                    if (pre_go) begin
                        state_q <= BK_IDLE;
                        age_q   <= '0;
                    end else if (age_q < MAX_L) begin
                        age_q <= age_q + CNT_W'(1);
                    end
                end
            endcase
        end
    end

    assign is_open    = (state_q == BK_OPEN);
    assign open_row   = row_q;
    assign rd_ok      = is_open && (age_q >= RCD_L);
    assign pre_ok     = is_open && (age_q >= MIN_L);
    assign must_close = is_open && (age_q >= MAX_L);

    // R5
    rcd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |-> (state_q == BK_OPEN) && (age_q >= RCD_L));

    // R6
    ras_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_go && state_q == BK_OPEN) |-> (age_q >= MIN_L));

    // R7
    ras_max_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        must_close |=> (state_q == BK_IDLE));

    // R9
    act_idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_go |-> (state_q == BK_IDLE));
endmodule

// File: rtl/sdram_cmd_pick.sv
module sdram_cmd_pick
    import sdram_seq_pkg::*;
#(
    parameter int ROW_W = 11
) (
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [BK_W-1:0]  req_bank,
    input  logic [ROW_W-1:0] req_row,
    input  logic [BANKS-1:0] is_open,
    input  logic [ROW_W-1:0] open_row [BANKS],
    input  logic [BANKS-1:0] rd_ok,
    input  logic [BANKS-1:0] pre_ok,
    input  logic [BANKS-1:0] must_close,
    output logic             req_ready,
    output cmd_state_e       nxt_cmd,
    output logic [BK_W-1:0]  nxt_bank,
    output logic             nxt_err,
    output logic [BANKS-1:0] act_go,
    output logic [BANKS-1:0] rd_go,
    output logic [BANKS-1:0] pre_go
);
    logic [BK_W-1:0] force_bank;

    always_comb begin
        force_bank = '0;
        for (int i = BANKS - 1; i >= 0; i--) begin
            if (must_close[i]) force_bank = BK_W'(i);
        end
    end

    always_comb begin
        req_ready = 1'b1;
        nxt_cmd   = CS_NOP;
        nxt_bank  = req_bank;
        nxt_err   = 1'b0;
        act_go    = '0;
        rd_go     = '0;
        pre_go    = '0;
        if (|must_close) begin
            req_ready           = 1'b0;
            nxt_cmd             = CS_FPRE;
            nxt_bank            = force_bank;
            pre_go[force_bank]  = 1'b1;
        end else if (req_valid) begin
            unique case (req_op_e'(req_op))
                OP_ACT: begin
                    if (is_open[req_bank]) begin
                        nxt_err = 1'b1;
                    end else begin
                        nxt_cmd          = CS_ACT;
                        act_go[req_bank] = 1'b1;
                    end
                end
                OP_RD: begin
                    if (!is_open[req_bank] || open_row[req_bank] != req_row) begin
                        nxt_err = 1'b1;
                    end else if (!rd_ok[req_bank]) begin
                        req_ready = 1'b0;
                    end else begin
                        nxt_cmd         = CS_RD;
                        rd_go[req_bank] = 1'b1;
                    end
                end
                OP_PRE: begin
                    if (!is_open[req_bank]) begin
                        nxt_err = 1'b1;
                    end else if (!pre_ok[req_bank]) begin
                        req_ready = 1'b0;
                    end else begin
                        nxt_cmd          = CS_PRE;
                        pre_go[req_bank] = 1'b1;
                    end
                end
                OP_PALL: begin
                    if (|(is_open & ~pre_ok)) begin
                        req_ready = 1'b0;
                    end else begin
                        nxt_cmd  = CS_PALL;
                        nxt_bank = '0;
                        pre_go   = is_open;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/sdram_cmd_sequencer.sv
module sdram_cmd_sequencer
    import sdram_seq_pkg::*;
#(
    parameter int ROW_W     = 11,
    parameter int COL_W     = 8,
    parameter int T_RCD     = 3,
    parameter int T_RAS_MIN = 6,
    parameter int T_RAS_MAX = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_op,
    input  logic               req_bank,
    input  logic [ROW_W-1:0]   req_row,
    input  logic [COL_W-1:0]   req_col,
    output logic               req_ready,
    output logic               cmd_ras_n,
    output logic               cmd_cas_n,
    output logic               cmd_we_n,
    output logic [ROW_W:0]     cmd_addr,
    output logic               req_err
);
    localparam int ADDR_W = ROW_W + 1;
    localparam int BA_BIT = ADDR_W - 1;
    localparam int AP_BIT = ROW_W - 1;

    logic [BANKS-1:0] is_open, rd_ok, pre_ok, must_close;
    logic [BANKS-1:0] act_go, rd_go, pre_go;
    logic [ROW_W-1:0] open_row [BANKS];

    cmd_state_e       nxt_cmd, cmd_q;
    logic [BK_W-1:0]  nxt_bank, bank_q;
    logic             nxt_err, err_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        sdram_bank_track #(
            .ROW_W    (ROW_W),
            .T_RCD    (T_RCD),
            .T_RAS_MIN(T_RAS_MIN),
            .T_RAS_MAX(T_RAS_MAX)
        ) u_track (
            .clk       (clk),
            .rst_n     (rst_n),
            .act_go    (act_go[b]),
            .rd_go     (rd_go[b]),
            .pre_go    (pre_go[b]),
            .act_row   (req_row),
            .is_open   (is_open[b]),
            .open_row  (open_row[b]),
            .rd_ok     (rd_ok[b]),
            .pre_ok    (pre_ok[b]),
            .must_close(must_close[b])
        );
    end

    sdram_cmd_pick #(.ROW_W(ROW_W)) u_pick (
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_bank  (req_bank),
        .req_row   (req_row),
        .is_open   (is_open),
        .open_row  (open_row),
        .rd_ok     (rd_ok),
        .pre_ok    (pre_ok),
        .must_close(must_close),
        .req_ready (req_ready),
        .nxt_cmd   (nxt_cmd),
        .nxt_bank  (nxt_bank),
        .nxt_err   (nxt_err),
        .act_go    (act_go),
        .rd_go     (rd_go),
        .pre_go    (pre_go)
    );

    // command state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= CS_NOP;
            bank_q <= '0;
            row_q  <= '0;
            col_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            cmd_q  <= nxt_cmd;
            bank_q <= nxt_bank;
            row_q  <= req_row;
            col_q  <= req_col;
            err_q  <= nxt_err;
        end
    end

    // pin decode from command state
    always_comb begin
        cmd_ras_n = 1'b1;
        cmd_cas_n = 1'b1;
        cmd_we_n  = 1'b1;
        cmd_addr  = '0;
        unique case (cmd_q)
            CS_NOP: ;
            CS_ACT: begin
                cmd_ras_n              = 1'b0;
                cmd_addr[ROW_W-1:0]    = row_q;
                cmd_addr[BA_BIT]       = bank_q;
            end
            CS_RD: begin
                cmd_cas_n              = 1'b0;
                cmd_addr[COL_W-1:0]    = col_q;
                cmd_addr[BA_BIT]       = bank_q;
            end
            CS_PRE, CS_FPRE: begin
                cmd_ras_n              = 1'b0;
                cmd_we_n               = 1'b0;
                cmd_addr[BA_BIT]       = bank_q;
            end
            CS_PALL: begin
                cmd_ras_n              = 1'b0;
                cmd_we_n               = 1'b0;
                cmd_addr[AP_BIT]       = 1'b1;
            end
            default: ;
        endcase
    end

    assign req_err = err_q;

    // R7
    forced_close_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|must_close) |=> (!cmd_ras_n && cmd_cas_n && !cmd_we_n && !cmd_addr[AP_BIT]));

    // R9
    err_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (cmd_ras_n && cmd_cas_n && cmd_we_n));

    // R10
    idle_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !(|must_close)) |=> (cmd_ras_n && cmd_cas_n && cmd_we_n && cmd_addr == '0));

    // R9
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_err && !$past(req_valid && req_ready)) |-> 1'b0);
endmodule

// File: tb/sdram_cmd_sequencer_bench.sv
module sdram_cmd_sequencer_bench;
    localparam int TRCD = 3;
    localparam int TMIN = 5;
    localparam int TMAX = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic        req_bank = 1'b0;
    logic [10:0] req_row = '0;
    logic [7:0]  req_col = '0;
    logic        req_ready, cmd_ras_n, cmd_cas_n, cmd_we_n, req_err;
    logic [11:0] cmd_addr;

    int cyc = 0;
    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdram_cmd_sequencer #(
        .T_RCD(TRCD), .T_RAS_MIN(TMIN), .T_RAS_MAX(TMAX)
    ) u_sdram_cmd_sequencer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_ready(req_ready), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n),
        .cmd_we_n(cmd_we_n), .cmd_addr(cmd_addr), .req_err(req_err)
    );

    function automatic int pins();
        return {29'd0, cmd_ras_n, cmd_cas_n, cmd_we_n};
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after acceptance
    task automatic send(input int op, input int b, input int row, input int col,
                        output int acc);
        req_valid = 1'b1;
        req_op    = op[1:0];
        req_bank  = b[0];
        req_row   = row[10:0];
        req_col   = col[7:0];
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        acc = cyc + 1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic close_all();
        int a;
        send(3, 0, 0, 0, a);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int a, a1, r, p, t0, f;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(pins() == 7, "R1", "pins", pins(), 7);
        chk(cmd_addr == 0, "R1", "addr", cmd_addr, 0);
        chk(req_err == 0, "R1", "err", req_err, 0);
        chk(req_ready == 1, "R1", "ready", req_ready, 1);

        // R2 open encoding sweep, R4 close-both encoding
        for (int b = 0; b < 2; b++) begin
            for (int k = 0; k < 5; k++) begin
                int row;
                row = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 1023 : (k == 3) ? 2047 : 12'h555;
                send(0, b, row, 0, a);
                chk(pins() == 3, "R2", "act pins", pins(), 3);
                chk(cmd_addr == ((b << 11) | row), "R2", "act addr", cmd_addr, (b << 11) | row);
                chk(req_err == 0, "R2", "act err", req_err, 0);
                send(3, 0, 0, 0, p);
                chk(p == a + TMIN, "R6", "pall edge", p - a, TMIN);
                chk(pins() == 2 && cmd_addr == 12'h400, "R4", "pall addr", cmd_addr, 12'h400);
            end
        end

        // R5 read spacing sweep, R3 read encoding
        for (int b = 0; b < 2; b++) begin
            for (int g = 0; g < 6; g++) begin
                send(0, b, 7 + g, 0, a);
                repeat (g) @(negedge clk);
                send(1, b, 7 + g, 8'h80 | g, r);
                chk(r == imax(a + g + 1, a + TRCD), "R5", "read edge", r - a, imax(g + 1, TRCD));
                chk(pins() == 5, "R3", "read pins", pins(), 5);
                chk(cmd_addr == ((b << 11) | 8'h80 | g), "R3", "read addr", cmd_addr, (b << 11) | 8'h80 | g);
                close_all();
            end
        end

        // R6 single close spacing sweep, R4 single close encoding, R8 reopen
        for (int g = 0; g < 8; g++) begin
            int b;
            b = g % 2;
            send(0, b, 100 + g, 0, a);
            chk(req_err == 0, "R8", "reopen err", req_err, 0);
            repeat (g) @(negedge clk);
            send(2, b, 0, 0, p);
            chk(p == imax(a + g + 1, a + TMIN), "R6", "pre edge", p - a, imax(g + 1, TMIN));
            chk(pins() == 2, "R4", "pre pins", pins(), 2);
            chk(cmd_addr == (b << 11), "R4", "pre addr", cmd_addr, b << 11);
        end

        // R7 forced close timing
        for (int b = 0; b < 2; b++) begin
            send(0, b, 33, 0, a);
            f = -1;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (pins() == 2) begin
                    f = cyc;
                    break;
                end
            end
            chk(f == a + TMAX, "R7", "forced edge", f - a, TMAX);
            chk(cmd_addr == (b << 11), "R7", "forced addr", cmd_addr, b << 11);
            send(0, b, 34, 0, a);
            chk(req_err == 0, "R8", "open after forced", req_err, 0);
            close_all();
        end

        // R7 user request colliding with forced close is delayed
        send(0, 0, 9, 0, a);
        repeat (TMAX - 1) @(negedge clk);
        send(0, 1, 10, 0, a1);
        chk(a1 == a + TMAX + 1, "R7", "collide edge", a1 - a, TMAX + 1);
        chk(pins() == 3 && req_err == 0, "R7", "collide act", pins(), 3);
        close_all();

        // R6 close-both waits for the later bank, R8 close-both on idle banks
        send(0, 0, 1, 0, a);
        send(0, 1, 2, 0, a1);
        send(3, 0, 0, 0, p);
        chk(p == a1 + TMIN, "R6", "pall both edge", p - a1, TMIN);
        t0 = cyc;
        send(3, 1, 0, 0, p);
        chk(p == t0 + 1, "R8", "pall idle edge", p - t0, 1);
        chk(req_err == 0 && pins() == 2, "R8", "pall idle", req_err, 0);
        chk(cmd_addr == 12'h400, "R4", "pall addr bank1 req", cmd_addr, 12'h400);

        // R9 illegal requests
        t0 = cyc;
        send(1, 0, 0, 0, p);
        chk(p == t0 + 1, "R9", "rd idle edge", p - t0, 1);
        chk(req_err == 1 && pins() == 7, "R9", "rd idle err", req_err, 1);
        @(negedge clk);
        chk(req_err == 0, "R9", "err one cycle", req_err, 0);
        chk(pins() == 7 && cmd_addr == 0, "R10", "idle nop", pins(), 7);
        send(2, 1, 0, 0, p);
        chk(req_err == 1 && pins() == 7, "R9", "pre idle err", req_err, 1);
        send(0, 0, 5, 0, a);
        send(0, 0, 6, 0, p);
        chk(req_err == 1 && pins() == 7, "R9", "act open err", req_err, 1);
        repeat (TRCD) @(negedge clk);
        t0 = cyc;
        send(1, 0, 6, 3, p);
        chk(p == t0 + 1 && req_err == 1, "R9", "row miss err", req_err, 1);
        chk(pins() == 7, "R9", "row miss pins", pins(), 7);
        send(1, 0, 5, 3, p);
        chk(req_err == 0 && pins() == 5, "R9", "row hit after miss", pins(), 5);
        close_all();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule